// File: doc/BRIEF.md
# Serial Asynchronous Receive Engine

This block turns an asynchronous serial line into parallel characters. A 16x oversampling tick comes from the system clock through a selectable prescaler. A falling edge on the line starts a frame. The low start level is confirmed half a bit later, and each following bit is sampled at its centre. Characters of 7, 8 or 9 bits are supported. A parity bit can be included, with even or odd sense, and one or two stop bits can follow. Every accepted character lands in a one-entry holding register, where the parity, framing and overrun status flags record the outcome.

Software controls the engine through a write strobe that carries two bits: enable and init. Clearing enable stops new frames from starting, but a frame already on the line still completes. Init is a one-cycle command. It aborts any frame in flight, clears every status flag and drops enable. In 9-bit mode an address filter can hold off storage until a character with its ninth bit set arrives. A flow-control output asks the far end to pause whenever the engine cannot take another character.

Top module: `uart_rx_engine`

## Requirements
- R1: After reset, `flag_full`, `flag_perr`, `flag_ferr`, `flag_ovr` and `rx_enabled` are 0, and `rts_n` is 1.
- R2: `cfg_len` selects the character length: 00 gives 7 bits, 01 gives 8 bits and 10 gives 9 bits. Bits arrive LSB first. The character is right-aligned in `rd_data`, and unused upper bits read 0. Storing a character sets `flag_full`.
- R3: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 means even parity and 1 means odd. On a mismatch, `flag_perr` is set and stays set until init.
- R4: A low level at the centre of the first stop bit sets `flag_ferr`, which stays set until init. `cfg_two_stop`=1 adds a second stop bit, and that bit is not checked.
- R5: A character that completes while `flag_full` is 1 sets `flag_ovr` and is discarded; `rd_data` keeps the earlier character.
- R6: A one-cycle `rd_stb` clears `flag_full`.
- R7: A `ctl_wr` pulse loads `ctl_enable` into `rx_enabled`. Clearing it during a frame lets that frame complete and be stored. No later start edge is accepted while `rx_enabled` is 0.
- R8: A `ctl_wr` pulse with `ctl_init`=1 creates an internal init pulse lasting exactly one cycle. That pulse clears all four flags and `rx_enabled`, and it drops any frame in progress without storing it.
- R9: With `cfg_addr_mode`=1 and `cfg_len`=10, characters are dropped until one arrives with bit 8 set. That character is stored, and so is every character after it, until the next init.
- R10: `rts_n` is active low and registered. It is 0 only when `cfg_rts_en`=1, `rx_enabled`=1 and `flag_full`=0; otherwise it is 1.
- R11: `cfg_ps` values 00, 01, 10 and 11 divide the oversampling tick by 1, 8, 32 and 256. One bit time is 16·BASE_DIV·factor clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_addr_mode | input | 1 | Address filtering on |
| cfg_ps | input | 2 | Prescaler select |
| cfg_rts_en | input | 1 | Drive flow-control output |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable value written |
| ctl_init | input | 1 | Init command written |
| rxd | input | 1 | Serial input line |
| rd_stb | input | 1 | Buffer read strobe |
| rd_data | output | 9 | Received character |
| rx_enabled | output | 1 | Current enable state |
| flag_full | output | 1 | Buffer holds a character |
| flag_perr | output | 1 | Parity error seen |
| flag_ferr | output | 1 | Framing error seen |
| flag_ovr | output | 1 | Overrun seen |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The assertions assume the following about the inputs:
- The configuration inputs stay fixed while a frame is on the line.
- `ctl_wr` never arrives in the same cycle as the internal init pulse.
- BASE_DIV is at least 2, so that oversampling ticks are never back to back.

The stimulus changes configuration only between frames, after the engine is idle, and it spaces every control write well apart. The serial line is driven at the exact nominal bit time, and the line idles high for two bit times between frames. Mid-frame commands are issued from a parallel thread, a few bit times into the frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_CHAR = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [MAX_CHAR-1:0] data;
    logic                perr;
    logic                ferr;
  } rx_frame_t;

  function automatic logic [3:0] char_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd7;
      2'b01:   return 4'd8;
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ps,
  output logic       tick
);
  localparam int MAX_DIV = BASE_DIV * 256;
  localparam int CW      = $clog2(MAX_DIV);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (ps)
      2'b00:   lim = CW'(BASE_DIV - 1);
      2'b01:   lim = CW'(BASE_DIV * 8 - 1);
      2'b10:   lim = CW'(BASE_DIV * 32 - 1);
      default: lim = CW'(MAX_DIV - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (cnt >= lim) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R11: ticks are isolated pulses when BASE_DIV >= 2
  assert_tick_isolated_R11: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       en_i,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic [1:0] cfg_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  output logic       frm_valid,
  output rx_frame_t  frm
);
  localparam int          CW   = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e             st;
  logic [CW-1:0]         cnt;
  logic [3:0]            bitn;
  logic [MAX_CHAR-1:0]   sh;
  logic                  pbit, ferr_hold, rxd_d;
  logic [3:0]            nbits;
  logic [MAX_CHAR-1:0]   aligned;
  logic                  perr_c, at_bit;

  always_comb begin
    nbits   = char_bits(cfg_len);
    aligned = sh >> (4'd9 - nbits);
    perr_c  = par_en & (^aligned ^ pbit ^ par_odd);
    at_bit  = tick && (cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      sh        <= '0;
      pbit      <= 1'b0;
      ferr_hold <= 1'b0;
      rxd_d     <= 1'b1;
      frm_valid <= 1'b0;
      frm       <= '0;
    end else begin
      rxd_d     <= rxd_s;
      frm_valid <= 1'b0;
      if (tick) cnt <= cnt + 1'b1;
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (en_i && rxd_d && !rxd_s) st <= ST_START;
        end
        ST_START: if (tick && cnt == MID) begin
          cnt  <= '0;
          bitn <= '0;
          st   <= rxd_s ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (at_bit) begin
          sh   <= {rxd_s, sh[MAX_CHAR-1:1]};
          bitn <= bitn + 1'b1;
          if (bitn == nbits - 1'b1) st <= par_en ? ST_PAR : ST_STOP1;
        end
        ST_PAR: if (at_bit) begin
          pbit <= rxd_s;
          st   <= ST_STOP1;
        end
        ST_STOP1: if (at_bit) begin
          if (two_stop) begin
            ferr_hold <= !rxd_s;
            st        <= ST_STOP2;
          end else begin
            frm       <= '{data: aligned, perr: perr_c, ferr: !rxd_s};
            frm_valid <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_STOP2: if (at_bit) begin
          frm       <= '{data: aligned, perr: perr_c, ferr: ferr_hold};
          frm_valid <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: a frame only begins while reception is enabled
  assert_start_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && $past(st) == ST_IDLE) |-> $past(en_i));
  // R2: one completion pulse per frame
  assert_single_done_R2: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> !frm_valid);
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int BASE_DIV  = 4,
  parameter int OVS       = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       cfg_addr_mode,
  input  logic [1:0] cfg_ps,
  input  logic       cfg_rts_en,
  input  logic       ctl_wr,
  input  logic       ctl_enable,
  input  logic       ctl_init,
  input  logic       rxd,
  input  logic       rd_stb,
  output logic [8:0] rd_data,
  output logic       rx_enabled,
  output logic       flag_full,
  output logic       flag_perr,
  output logic       flag_ferr,
  output logic       flag_ovr,
  output logic       rts_n
);
  logic [SYNC_LEN-1:0] sync_q;
  logic                tick, frm_valid, init_q, addr_seen, addr_filter, accept;
  rx_frame_t           frm;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_LEN-2:0], rxd};
  end

  rx_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk(clk), .rst(rst), .ps(cfg_ps), .tick(tick)
  );

  rx_frame_fsm #(.OVS(OVS)) u_fsm (
    .clk(clk), .rst(rst), .abort(init_q), .en_i(rx_enabled), .tick(tick),
    .rxd_s(sync_q[SYNC_LEN-1]), .cfg_len(cfg_len), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .two_stop(cfg_two_stop),
    .frm_valid(frm_valid), .frm(frm)
  );

  always_comb begin
    addr_filter = cfg_addr_mode && (cfg_len == 2'b10);
    accept      = !addr_filter || addr_seen || frm.data[8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q     <= 1'b0;
      rx_enabled <= 1'b0;
      flag_full  <= 1'b0;
      flag_perr  <= 1'b0;
      flag_ferr  <= 1'b0;
      flag_ovr   <= 1'b0;
      addr_seen  <= 1'b0;
      rd_data    <= '0;
      rts_n      <= 1'b1;
    end else begin
      init_q <= ctl_wr && ctl_init;
      rts_n  <= !(cfg_rts_en && rx_enabled && !flag_full);
      if (init_q) begin
        rx_enabled <= 1'b0;
        flag_full  <= 1'b0;
        flag_perr  <= 1'b0;
        flag_ferr  <= 1'b0;
        flag_ovr   <= 1'b0;
        addr_seen  <= 1'b0;
      end else begin
        if (ctl_wr) rx_enabled <= ctl_enable;
        if (rd_stb) flag_full <= 1'b0;
        if (frm_valid && accept) begin
          addr_seen <= addr_seen | (addr_filter & frm.data[8]);
          if (flag_full && !rd_stb) begin
            flag_ovr <= 1'b1;
          end else begin
            rd_data   <= frm.data;
            flag_full <= 1'b1;
            flag_perr <= flag_perr | frm.perr;
            flag_ferr <= flag_ferr | frm.ferr;
          end
        end
      end
    end
  end

  // R8: init wipes status and enable in the following cycle
  assert_init_clears_R8: assert property (@(posedge clk) disable iff (rst)
    init_q |=> (!rx_enabled && !flag_full && !flag_perr && !flag_ferr && !flag_ovr));
  // R8: init lasts one cycle unless rewritten
  assert_init_oneshot_R8: assert property (@(posedge clk) disable iff (rst)
    (init_q && !ctl_wr) |=> !init_q);
  // R5: completion into a full buffer raises overrun and keeps old data
  assert_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && accept && flag_full && !rd_stb && !init_q) |=> (flag_ovr && $stable(rd_data)));
  // R10: no request while the buffer is occupied
  assert_rts_full_R10: assert property (@(posedge clk) disable iff (rst)
    $past(flag_full) |-> rts_n);
  // R10: output idle when the function is off
  assert_rts_off_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_rts_en |=> rts_n);
endmodule

// File: tb/uart_rx_engine_test.sv
module uart_rx_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_len = 2'b01, cfg_ps = 2'b00;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_addr_mode = 0, cfg_rts_en = 0;
  logic ctl_wr = 0, ctl_enable = 0, ctl_init = 0, rxd = 1, rd_stb = 0;
  logic [8:0] rd_data;
  logic rx_enabled, flag_full, flag_perr, flag_ferr, flag_ovr, rts_n;
  int n_chk = 0, n_bad = 0, bitclk = 64;

  always #5 clk = ~clk;

  uart_rx_engine uut (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_addr_mode(cfg_addr_mode), .cfg_ps(cfg_ps), .cfg_rts_en(cfg_rts_en),
    .ctl_wr(ctl_wr), .ctl_enable(ctl_enable), .ctl_init(ctl_init), .rxd(rxd),
    .rd_stb(rd_stb), .rd_data(rd_data), .rx_enabled(rx_enabled),
    .flag_full(flag_full), .flag_perr(flag_perr), .flag_ferr(flag_ferr),
    .flag_ovr(flag_ovr), .rts_n(rts_n)
  );

  typedef struct packed {
    logic [1:0] len; logic par_en; logic par_odd; logic two_stop;
    logic bad_par; logic bad_stop; logic [8:0] data;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A3},
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1C6},
    '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h03C},
    '{2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h081},
    '{2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h02B},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h07E},
    '{2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9'h0F1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic ctl(input logic en, input logic ini);
    @(negedge clk);
    ctl_wr = 1; ctl_enable = en; ctl_init = ini;
    @(negedge clk);
    ctl_wr = 0; ctl_enable = 0; ctl_init = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input int nb, input logic [8:0] d, input logic use_par,
                      input logic pbit, input logic two, input logic stop_lvl);
    @(negedge clk);
    rxd = 0; repeat (bitclk) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; repeat (bitclk) @(negedge clk);
    end
    if (use_par) begin rxd = pbit; repeat (bitclk) @(negedge clk); end
    rxd = stop_lvl; repeat (bitclk) @(negedge clk);
    if (two) begin rxd = 1; repeat (bitclk) @(negedge clk); end
    rxd = 1; repeat (2 * bitclk) @(negedge clk);
  endtask

  function automatic int nbits(input logic [1:0] c);
    return (c == 2'b00) ? 7 : (c == 2'b01) ? 8 : 9;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 full", flag_full, 0);
    check("R1 perr", flag_perr, 0);
    check("R1 ferr", flag_ferr, 0);
    check("R1 ovr", flag_ovr, 0);
    check("R1 enabled", rx_enabled, 0);
    check("R1 rts_n", rts_n, 1);

    // table walk: R2 R3 R4 R6
    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      int nb = nbits(v.len);
      logic [8:0] m = 9'((1 << nb) - 1);
      logic [8:0] d = v.data & m;
      logic p = (^d) ^ v.par_odd ^ v.bad_par;
      cfg_len = v.len; cfg_par_en = v.par_en; cfg_par_odd = v.par_odd;
      cfg_two_stop = v.two_stop;
      ctl(0, 1);
      ctl(1, 0);
      send(nb, d, v.par_en, p, v.two_stop, !v.bad_stop);
      check("R2 full", flag_full, 1);
      check("R2 data", rd_data, d);
      check("R3 perr", flag_perr, v.par_en & v.bad_par);
      check("R4 ferr", flag_ferr, v.bad_stop);
      do_read();
      check("R6 read clears full", flag_full, 0);
    end

    // R10 flow control
    cfg_len = 2'b01; cfg_par_en = 0; cfg_two_stop = 0; cfg_rts_en = 1;
    ctl(0, 1);
    check("R10 rts off when disabled", rts_n, 1);
    ctl(1, 0);
    check("R10 rts asserted", rts_n, 0);
    send(8, 9'h05A, 0, 0, 0, 1);
    check("R10 rts when full", rts_n, 1);
    do_read();
    check("R10 rts after read", rts_n, 0);
    cfg_rts_en = 0;
    repeat (3) @(negedge clk);
    check("R10 rts function off", rts_n, 1);

    // R5 overrun
    send(8, 9'h011, 0, 0, 0, 1);
    send(8, 9'h022, 0, 0, 0, 1);
    check("R5 ovr", flag_ovr, 1);
    check("R5 data kept", rd_data, 9'h011);
    // R8 init clears flags and enable
    ctl(0, 1);
    check("R8 ovr cleared", flag_ovr, 0);
    check("R8 full cleared", flag_full, 0);
    check("R8 enable cleared", rx_enabled, 0);

    // R8 abort mid-frame
    ctl(1, 0);
    fork
      send(8, 9'h0C3, 0, 0, 0, 1);
      begin repeat (4 * bitclk) @(negedge clk); ctl(1, 1); end
    join
    check("R8 aborted frame dropped", flag_full, 0);
    check("R8 enable dropped", rx_enabled, 0);

    // R7 disable mid-frame completes
    ctl(1, 0);
    fork
      send(8, 9'h03E, 0, 0, 0, 1);
      begin repeat (4 * bitclk) @(negedge clk); ctl(0, 0); end
    join
    check("R7 frame completes", flag_full, 1);
    check("R7 data", rd_data, 9'h03E);
    do_read();
    send(8, 9'h044, 0, 0, 0, 1);
    check("R7 no new start", flag_full, 0);

    // R9 address filtering
    cfg_len = 2'b10; cfg_addr_mode = 1;
    ctl(0, 1);
    ctl(1, 0);
    send(9, 9'h055, 0, 0, 0, 1);
    check("R9 data before address dropped", flag_full, 0);
    send(9, 9'h1A5, 0, 0, 0, 1);
    check("R9 address stored", rd_data, 9'h1A5);
    do_read();
    send(9, 9'h033, 0, 0, 0, 1);
    check("R9 data after address", flag_full, 1);
    check("R9 data value", rd_data, 9'h033);
    ctl(0, 1);
    ctl(1, 0);
    send(9, 9'h033, 0, 0, 0, 1);
    check("R9 filter rearmed by init", flag_full, 0);

    // R11 prescaler divide by 8
    cfg_addr_mode = 0; cfg_len = 2'b01; cfg_ps = 2'b01; bitclk = 512;
    ctl(0, 1);
    ctl(1, 0);
    send(8, 9'h0B7, 0, 0, 0, 1);
    check("R11 full at slow rate", flag_full, 1);
    check("R11 data at slow rate", rd_data, 9'h0B7);

    finish_run();
  end
endmodule